// File: doc/BRIEF.md
# Presence-Vector Home Directory Controller

This block sits at the home node of a small shared-memory system and keeps coherence for every memory block it owns. For each block it holds a presence vector with one bit per processor and a dirty flag. Together they give three block states. A block with no presence bits set is Uncached. A block with presence bits set and the dirty flag clear is Shared, with memory up to date. A block with the dirty flag set is Exclusive: exactly one owner holds it and memory is stale. The block also holds the backing memory words.

A cache that misses sends a read-miss or write-miss request carrying its processor number and block address. The controller handles one request at a time. It sends messages only to the processors marked in the presence vector, never to all of them:
- invalidates to the other sharers when a block is written,
- a fetch or fetch-and-invalidate to an Exclusive owner,
- a data reply to the requester once the required round is complete.

While it waits for an owner's write-back, it holds its request input not ready. The owner's data write-back arrives on a separate input and updates memory before the reply is built. One outgoing message is issued per cycle, in the order the protocol needs. The requester treats its data reply as the completion of its miss.

Top module: `dir_ctrl`

## Requirements
- R1: After reset every block is Uncached, memory word i holds the value i, `reqReady` is high and `msgValid` is low.
- R2: A read miss to an Uncached or Shared block produces exactly one message, in the cycle after acceptance: a reply (msgKind 1) to the requester carrying the memory word. The requester is added as a sharer.
- R3: A read miss to an Exclusive block first sends a fetch (msgKind 3) to the owner in the cycle after acceptance. Once the owner's write-back is taken, memory is updated and the next cycle carries a reply holding the written-back data. The dirty flag is cleared and both owner and requester remain sharers.
- R4: A write miss to an Uncached block produces a reply in the cycle after acceptance. The requester becomes the sole holder and the block becomes Exclusive.
- R5: A write miss to a Shared block scans processors in ascending index order, one per cycle, and sends an invalidate (msgKind 2) to every sharer except the requester. The reply follows in cycle NUM_PROCS+1 after acceptance, leaving the requester as the Exclusive owner.
- R6: A write miss to an Exclusive block sends a fetch-and-invalidate (msgKind 4) to the owner. It waits for the write-back, stores it to memory and replies with that data. The requester becomes the sole owner and the block stays dirty.
- R7: A write-back is taken only while the controller is waiting for one and only when its address matches the pending block. Any other write-back changes neither memory nor the sequence.
- R8: `reqReady` is low from the cycle after acceptance through the reply cycle, and high again in the cycle after the reply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Miss request present |
| reqReady | output | 1 | Controller can accept a request |
| reqWrite | input | 1 | 1 = write miss, 0 = read miss |
| reqProc | input | PW | Requesting processor number |
| reqAddr | input | AW | Requested block address |
| wbValid | input | 1 | Owner data write-back present |
| wbAddr | input | AW | Write-back block address |
| wbData | input | DATA_W | Write-back data |
| msgValid | output | 1 | Outgoing message valid |
| msgKind | output | 3 | 1 reply, 2 invalidate, 3 fetch, 4 fetch-and-invalidate, 0 none |
| msgDest | output | PW | Destination processor |
| msgAddr | output | AW | Block address of the message |
| msgData | output | DATA_W | Reply data (zero for other kinds) |

## Verification
A reply with no round trip is due one cycle after the accepting edge. A write to a Shared block is due NUM_PROCS+1 cycles after acceptance, with each invalidate in the cycle its processor index is scanned. With an owner involved, the fetch comes in the first cycle, and the reply comes one cycle after the edge that takes the matching write-back. The bench derives each of these cycle numbers from its own model of the presence vectors before it sends the request. It samples every output on the falling edge and counts cycles from acceptance, so a message that comes early, late or out of order fails its check. Write-backs are driven at fixed offsets from the fetch: first a mismatched one that must be ignored, then the real one.

// File: rtl/dir_pkg.sv
package dir_pkg;

  typedef enum logic [1:0] {
    BLK_UNCACHED = 2'd0,
    BLK_SHARED   = 2'd1,
    BLK_EXCL     = 2'd2
  } blk_state_e;

  typedef enum logic [2:0] {
    MSG_NONE      = 3'd0,
    MSG_REPLY     = 3'd1,
    MSG_INVAL     = 3'd2,
    MSG_FETCH     = 3'd3,
    MSG_FETCH_INV = 3'd4
  } msg_kind_e;

  typedef struct packed {
    logic      latchReq;
    logic      scanStep;
    logic      memWrite;
    logic      dirUpdate;
    msg_kind_e emit;
  } dir_strobe_t;

endpackage

// File: rtl/dir_datapath.sv
module dir_datapath
  import dir_pkg::*;
#(
  parameter int NUM_PROCS  = 4,
  parameter int NUM_BLOCKS = 8,
  parameter int DATA_W     = 16,
  parameter int PW         = (NUM_PROCS > 1) ? $clog2(NUM_PROCS) : 1,
  parameter int AW         = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  dir_strobe_t       strb,
  input  logic              reqWrite,
  input  logic [PW-1:0]     reqProc,
  input  logic [AW-1:0]     reqAddr,
  input  logic              wbValid,
  input  logic [AW-1:0]     wbAddr,
  input  logic [DATA_W-1:0] wbData,
  output blk_state_e        blkState,
  output logic              curWrite,
  output logic              scanLast,
  output logic              wbMatch,
  output logic              msgValid,
  output logic [2:0]        msgKind,
  output logic [PW-1:0]     msgDest,
  output logic [AW-1:0]     msgAddr,
  output logic [DATA_W-1:0] msgData
);

  logic [DATA_W-1:0]    memArr  [NUM_BLOCKS];
  logic [NUM_PROCS-1:0] presArr [NUM_BLOCKS];
  logic [NUM_BLOCKS-1:0] dirtyArr;
  logic [PW-1:0]        curProc;
  logic [PW-1:0]        scanIdx;
  logic [AW-1:0]        curAddr;
  logic [AW-1:0]        lookAddr;
  logic [NUM_PROCS-1:0] lookPres;
  logic [PW-1:0]        ownerIdx;
  logic                 invalHit;

  // Lookup uses the incoming address in the accept cycle, the held one after.
  assign lookAddr = strb.latchReq ? reqAddr : curAddr;
  assign lookPres = presArr[lookAddr];

  always_comb begin
    if (lookPres == '0)          blkState = BLK_UNCACHED;
    else if (dirtyArr[lookAddr]) blkState = BLK_EXCL;
    else                         blkState = BLK_SHARED;
  end

  // Owner of an Exclusive block: the lowest set presence bit.
  always_comb begin
    ownerIdx = '0;
    for (int i = NUM_PROCS - 1; i >= 0; i--) begin
      if (presArr[curAddr][i]) ownerIdx = PW'(i);
    end
  end

  assign scanLast = (scanIdx == PW'(NUM_PROCS - 1));
  assign wbMatch  = wbValid && (wbAddr == curAddr);
  assign invalHit = presArr[curAddr][scanIdx] && (scanIdx != curProc);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_BLOCKS; i++) begin
        memArr[i]  <= DATA_W'(i);
        presArr[i] <= '0;
      end
      dirtyArr <= '0;
      curWrite <= 1'b0;
      curProc  <= '0;
      curAddr  <= '0;
      scanIdx  <= '0;
    end else begin
      if (strb.latchReq) begin
        curWrite <= reqWrite;
        curProc  <= reqProc;
        curAddr  <= reqAddr;
        scanIdx  <= '0;
      end else if (strb.scanStep) begin
        scanIdx <= scanIdx + 1'b1;
      end
      if (strb.memWrite) memArr[curAddr] <= wbData;
      if (strb.dirUpdate) begin
        if (curWrite) begin
          presArr[curAddr]  <= NUM_PROCS'(1) << curProc;
          dirtyArr[curAddr] <= 1'b1;
        end else begin
          presArr[curAddr]  <= presArr[curAddr] | (NUM_PROCS'(1) << curProc);
          dirtyArr[curAddr] <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    msgValid = 1'b0;
    msgDest  = '0;
    unique case (strb.emit)
      MSG_REPLY:               begin msgValid = 1'b1;     msgDest = curProc;  end
      MSG_INVAL:               begin msgValid = invalHit; msgDest = scanIdx;  end
      MSG_FETCH, MSG_FETCH_INV: begin msgValid = 1'b1;    msgDest = ownerIdx; end
      default: ;
    endcase
  end

  assign msgKind = msgValid ? strb.emit : MSG_NONE;
  assign msgAddr = curAddr;
  assign msgData = (strb.emit == MSG_REPLY) ? memArr[curAddr] : '0;

endmodule

// File: rtl/dir_control.sv
module dir_control
  import dir_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  blk_state_e  blkState,
  input  logic        curWrite,
  input  logic        scanLast,
  input  logic        wbMatch,
  output logic        reqReady,
  output dir_strobe_t strb
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_INVAL, ST_FETCH, ST_WAIT, ST_REPLY
  } ctl_state_e;

  ctl_state_e state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strb      = '{latchReq: 1'b0, scanStep: 1'b0, memWrite: 1'b0,
                  dirUpdate: 1'b0, emit: MSG_NONE};
    reqReady  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strb.latchReq = 1'b1;
          if (blkState == BLK_EXCL)                       stateNext = ST_FETCH;
          else if (reqWrite && blkState == BLK_SHARED)    stateNext = ST_INVAL;
          else                                            stateNext = ST_REPLY;
        end
      end
      ST_INVAL: begin
        strb.emit     = MSG_INVAL;
        strb.scanStep = 1'b1;
        if (scanLast) stateNext = ST_REPLY;
      end
      ST_FETCH: begin
        strb.emit = curWrite ? MSG_FETCH_INV : MSG_FETCH;
        stateNext = ST_WAIT;
      end
      ST_WAIT: begin
        if (wbMatch) begin
          strb.memWrite = 1'b1;
          stateNext     = ST_REPLY;
        end
      end
      ST_REPLY: begin
        strb.emit      = MSG_REPLY;
        strb.dirUpdate = 1'b1;
        stateNext      = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/dir_ctrl.sv
module dir_ctrl
  import dir_pkg::*;
#(
  parameter int NUM_PROCS  = 4,
  parameter int NUM_BLOCKS = 8,
  parameter int DATA_W     = 16,
  parameter int PW         = (NUM_PROCS > 1) ? $clog2(NUM_PROCS) : 1,
  parameter int AW         = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [PW-1:0]     reqProc,
  input  logic [AW-1:0]     reqAddr,
  input  logic              wbValid,
  input  logic [AW-1:0]     wbAddr,
  input  logic [DATA_W-1:0] wbData,
  output logic              msgValid,
  output logic [2:0]        msgKind,
  output logic [PW-1:0]     msgDest,
  output logic [AW-1:0]     msgAddr,
  output logic [DATA_W-1:0] msgData
);

  dir_strobe_t strb;
  blk_state_e  blkState;
  logic        curWrite;
  logic        scanLast;
  logic        wbMatch;

  dir_control u_control (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .blkState (blkState),
    .curWrite (curWrite),
    .scanLast (scanLast),
    .wbMatch  (wbMatch),
    .reqReady (reqReady),
    .strb     (strb)
  );

  dir_datapath #(
    .NUM_PROCS(NUM_PROCS), .NUM_BLOCKS(NUM_BLOCKS), .DATA_W(DATA_W),
    .PW(PW), .AW(AW)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .reqWrite (reqWrite),
    .reqProc  (reqProc),
    .reqAddr  (reqAddr),
    .wbValid  (wbValid),
    .wbAddr   (wbAddr),
    .wbData   (wbData),
    .blkState (blkState),
    .curWrite (curWrite),
    .scanLast (scanLast),
    .wbMatch  (wbMatch),
    .msgValid (msgValid),
    .msgKind  (msgKind),
    .msgDest  (msgDest),
    .msgAddr  (msgAddr),
    .msgData  (msgData)
  );

endmodule

// File: rtl/dir_ctrl_chk.sv
module dir_ctrl_chk #(
  parameter int NUM_PROCS  = 4,
  parameter int NUM_BLOCKS = 8,
  parameter int DATA_W     = 16,
  parameter int PW         = (NUM_PROCS > 1) ? $clog2(NUM_PROCS) : 1,
  parameter int AW         = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              reqWrite,
  input logic [PW-1:0]     reqProc,
  input logic [AW-1:0]     reqAddr,
  input logic              wbValid,
  input logic [AW-1:0]     wbAddr,
  input logic [DATA_W-1:0] wbData,
  input logic              msgValid,
  input logic [2:0]        msgKind,
  input logic [PW-1:0]     msgDest,
  input logic [AW-1:0]     msgAddr,
  input logic [DATA_W-1:0] msgData
);

  logic          capWrite;
  logic [PW-1:0] capProc;
  logic [AW-1:0] capAddr;
  logic          waiting;
  logic          accept;
  logic          isReply;
  logic          isFetch;
  logic          wbTaken;

  assign accept  = reqValid && reqReady;
  assign isReply = msgValid && (msgKind == 3'd1);
  assign isFetch = msgValid && (msgKind == 3'd3 || msgKind == 3'd4);
  assign wbTaken = waiting && wbValid && (wbAddr == capAddr);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capWrite <= 1'b0;
      capProc  <= '0;
      capAddr  <= '0;
      waiting  <= 1'b0;
    end else begin
      if (accept) begin
        capWrite <= reqWrite;
        capProc  <= reqProc;
        capAddr  <= reqAddr;
      end
      if (isFetch)      waiting <= 1'b1;
      else if (wbTaken) waiting <= 1'b0;
    end
  end

  p_reply_to_requester_r2: assert property (@(posedge clk) disable iff (!rstN)
    isReply |-> (msgDest == capProc && msgAddr == capAddr));

  p_inval_skips_self_r5: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && msgKind == 3'd2) |-> (capWrite && msgDest != capProc));

  p_fetch_kind_r6: assert property (@(posedge clk) disable iff (!rstN)
    isFetch |-> ((msgKind == 3'd4) == capWrite));

  p_wb_then_reply_r3: assert property (@(posedge clk) disable iff (!rstN)
    wbTaken |=> (isReply && msgData == $past(wbData)));

  p_busy_after_accept_r8: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> !reqReady);

  p_ready_after_reply_r8: assert property (@(posedge clk) disable iff (!rstN)
    isReply |=> reqReady);

endmodule

bind dir_ctrl dir_ctrl_chk #(
  .NUM_PROCS(NUM_PROCS), .NUM_BLOCKS(NUM_BLOCKS), .DATA_W(DATA_W),
  .PW(PW), .AW(AW)
) u_chk (.*);

// File: tb/tb_dir_ctrl.sv
module tb_dir_ctrl;

  localparam int NP = 4;
  localparam int NB = 8;
  localparam int DW = 16;
  localparam int PW = $clog2(NP);
  localparam int AW = $clog2(NB);
  localparam time CLK_PERIOD = 10ns;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic          reqReady;
  logic          reqWrite = 1'b0;
  logic [PW-1:0] reqProc = '0;
  logic [AW-1:0] reqAddr = '0;
  logic          wbValid = 1'b0;
  logic [AW-1:0] wbAddr = '0;
  logic [DW-1:0] wbData = '0;
  logic          msgValid;
  logic [2:0]    msgKind;
  logic [PW-1:0] msgDest;
  logic [AW-1:0] msgAddr;
  logic [DW-1:0] msgData;

  int errors = 0;
  int checks = 0;

  logic [NP-1:0] mPres [NB];
  bit            mDirty [NB];
  logic [DW-1:0] mMem [NB];

  always #(CLK_PERIOD / 2) clk = ~clk;

  dir_ctrl #(.NUM_PROCS(NP), .NUM_BLOCKS(NB), .DATA_W(DW)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqProc(reqProc), .reqAddr(reqAddr),
    .wbValid(wbValid), .wbAddr(wbAddr), .wbData(wbData),
    .msgValid(msgValid), .msgKind(msgKind), .msgDest(msgDest),
    .msgAddr(msgAddr), .msgData(msgData)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int ownerOf(input int a);
    int o = 0;
    for (int i = NP - 1; i >= 0; i--) if (mPres[a][i]) o = i;
    return o;
  endfunction

  task automatic doReq(input bit w, input int p, input int a);
    int expK[8];
    int expD[8];
    int nExp = 0;
    int idx = 0;
    int replyCyc;
    int fetchCyc = 0;
    bit isEx;
    bit done = 0;
    string tag;
    logic [DW-1:0] wbVal;
    logic [DW-1:0] replyVal;

    isEx  = mDirty[a] && (mPres[a] != '0);
    wbVal = DW'($urandom);
    if (isEx) begin
      tag = w ? "R6" : "R3";
      expK[0] = w ? 4 : 3; expD[0] = ownerOf(a);
      expK[1] = 1;         expD[1] = p;
      nExp = 2; replyCyc = 4; replyVal = wbVal;
    end else if (w && mPres[a] != '0) begin
      tag = "R5";
      for (int j = 0; j < NP; j++) begin
        if (mPres[a][j] && j != p) begin
          expK[nExp] = 2; expD[nExp] = j; nExp++;
        end
      end
      expK[nExp] = 1; expD[nExp] = p; nExp++;
      replyCyc = NP + 1; replyVal = mMem[a];
    end else begin
      tag = w ? "R4" : "R2";
      expK[0] = 1; expD[0] = p; nExp = 1;
      replyCyc = 1; replyVal = mMem[a];
    end

    @(negedge clk);
    reqValid = 1'b1; reqWrite = w; reqProc = PW'(p); reqAddr = AW'(a);
    chk(reqReady == 1'b1, "R8", "ready when idle", reqReady, 1);
    @(negedge clk);
    reqValid = 1'b0;
    for (int cyc = 1; cyc <= 40 && !done; cyc++) begin
      wbValid = 1'b0;
      chk(reqReady == 1'b0, "R8", "ready while busy", reqReady, 0);
      if (fetchCyc != 0 && cyc == fetchCyc + 2)
        chk(msgValid == 1'b0, "R7", "message after stray write-back", msgValid, 0);
      if (msgValid) begin
        if (idx >= nExp) begin
          chk(1'b0, tag, "unexpected extra message kind", msgKind, 0);
        end else begin
          chk(msgKind == 3'(expK[idx]), tag, "message kind", msgKind, expK[idx]);
          chk(msgDest == PW'(expD[idx]), tag, "message dest", msgDest, expD[idx]);
          chk(msgAddr == AW'(a), tag, "message addr", msgAddr, a);
          if (msgKind == 3'd1) begin
            chk(cyc == replyCyc, tag, "reply cycle", cyc, replyCyc);
            chk(msgData == replyVal, tag, "reply data", msgData, replyVal);
            done = 1;
          end
          if (msgKind == 3'd3 || msgKind == 3'd4) fetchCyc = cyc;
          idx++;
        end
      end
      if (fetchCyc != 0 && cyc == fetchCyc + 1) begin
        wbValid = 1'b1; wbAddr = AW'((a + 1) % NB); wbData = ~wbVal;
      end else if (fetchCyc != 0 && cyc == fetchCyc + 2) begin
        wbValid = 1'b1; wbAddr = AW'(a); wbData = wbVal;
      end
      @(negedge clk);
    end
    wbValid = 1'b0;
    chk(done, tag, "reply seen", done, 1);
    chk(idx == nExp, tag, "message count", idx, nExp);
    chk(reqReady == 1'b1, "R8", "ready after reply", reqReady, 1);

    if (isEx) mMem[a] = wbVal;
    if (w) begin
      mPres[a] = NP'(1) << p;
      mDirty[a] = 1;
    end else begin
      mPres[a] = mPres[a] | (NP'(1) << p);
      mDirty[a] = 0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < NB; i++) begin
      mPres[i] = '0; mDirty[i] = 0; mMem[i] = DW'(i);
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady == 1'b1, "R1", "ready after reset", reqReady, 1);
    chk(msgValid == 1'b0, "R1", "no message after reset", msgValid, 0);

    // Stray write-back while idle must not touch memory.
    wbValid = 1'b1; wbAddr = AW'(2); wbData = 16'hBEEF;
    @(negedge clk);
    wbValid = 1'b0;
    chk(msgValid == 1'b0, "R7", "idle write-back message", msgValid, 0);

    doReq(0, 1, 2);  // R2 uncached read, returns reset word 2 (R1, R7)
    doReq(0, 0, 2);  // R2 shared read
    doReq(1, 3, 2);  // R5 invalidates P0 and P1
    doReq(0, 2, 2);  // R3 fetch from P3
    doReq(1, 0, 2);  // R5 invalidates P2 and P3
    doReq(1, 1, 2);  // R6 fetch-invalidate P0
    doReq(1, 0, 5);  // R4 uncached write
    doReq(0, 0, 5);  // R3 owner read of own block
    doReq(1, 2, 6);  // R4
    doReq(1, 2, 6);  // R6 owner rewrite

    for (int n = 0; n < 120; n++) begin
      doReq(1'($urandom), int'($urandom % NP), int'($urandom % NB));
    end

    // Final sweep of every block reflects the model's memory.
    for (int b = 0; b < NB; b++) doReq(0, 3, b);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule